// File: doc/BRIEF.md
# UART Banked Host Register File

This block is the host-facing register file of one UART channel. The host reaches it through an eight-location window addressed by a 3-bit offset, qualified by a chip select and separate read and write strobes. More registers exist than there are offsets. The divisor-access bit of the line control register selects between data/interrupt-enable and the divisor bytes at offsets 0 and 1. An unlock code written to line control opens the enhanced bank, and in that bank offset 2 reaches an additional control register.

The block stores line control, the 16-bit divisor, interrupt enable, modem control, scratch and additional control. It presents them to a separate UART core as configuration outputs. Accesses to the FIFO control, transmit and receive locations become single-cycle strobes toward the core. Reads of interrupt, line and modem status return words assembled from core inputs and from error and change flags held here.

Byte flow toward the core uses a valid-only push (`tx_valid_o`, `tx_data_o`) and a pop strobe (`rx_pop_o`). Neither carries back-pressure. The core must take every pushed byte, and the host finds room by reading the holding-empty status bit before it writes. Each strobe is high for exactly one cycle, the cycle after the access edge, provided the host holds a strobe for one clock per access.

Top module: `uart_regbank`

## Requirements
- R1: With line control bit 7 set, offset 0 reads and writes divisor bits 7:0 and offset 1 reads and writes divisor bits 15:8. The value appears on `divisor_o` after the write edge.
- R2: With line control bit 7 clear, a write to offset 0 gives `tx_valid_o` high for the one following cycle, with `tx_data_o` equal to the written byte. A read of offset 0 returns `rx_data_i` and gives `rx_pop_o` high for the one following cycle. Offset 1 is the interrupt enable register: bit 0 receive ready, bit 1 holding empty, bit 2 receive status, bit 3 modem status, bit 4 sleep. All 8 bits read back as written and drive `ier_o`.
- R3: Writing 0xBF to offset 3 sets `enh_mode_o` and line control bit 7, and leaves line control bits 6:0 unchanged. Writing any other value clears `enh_mode_o` and stores the whole byte. Line control bits are: 1:0 word length, 2 stop bits, 3 parity enable, 4 odd/even, 5 forced parity, 6 break, 7 divisor access.
- R4: While `enh_mode_o` is high, offset 2 reads and writes the additional control register. Its bit 7 drives `ext_bank_en_o` and its bit 6 drives `idx_bank_en_o`. Outside enhanced mode that register cannot change.
- R5: Outside enhanced mode, a write to offset 2 stores bit 0 as `fifo_en_o` and bit 3 as `dma_mode_o`. Bit 1 gives a one-cycle `rx_flush_o` pulse and bit 2 gives a one-cycle `tx_flush_o` pulse, and neither is stored. A read of offset 2 returns bits 7:6 both equal to `fifo_en_o`, bits 5:4 zero, bits 3:1 equal to `irq_code_i`, and bit 0 equal to the inverse of `irq_pend_i`.
- R6: Offset 5 reads line status. Bit 0 is receive ready, 1 overrun, 2 parity, 3 framing, 4 break, 5 holding empty, 6 transmitter empty, and 7 FIFO data error. Bits 1 to 4 latch one-cycle event inputs and clear when offset 5 is read. An event in the same cycle as the read stays set. The other bits follow their inputs.
- R7: Offset 6 reads modem status. Bit 4 is CTS, 5 DSR, 6 RI and 7 DCD. Bits 0, 1 and 3 latch any change of CTS, DSR and DCD. Bit 2 latches a 1-to-0 transition of RI. The four latched bits clear when offset 6 is read.
- R8: Modem control bits 4:0 read back at offset 4, with bits 7:5 reading zero. Bit 0 drives `dtr_o`, bit 1 `rts_o`, bit 3 `out2_o` and bit 4 `loop_o`. With bit 4 set, the modem status line bits take CTS from bit 1, DSR from bit 0, RI from bit 2 and DCD from bit 3.
- R9: Offset 7 is a scratch byte that reads back as written.
- R10: After reset, every stored register, every strobe and `enh_mode_o` are zero.
- R11: With `cs_i` low, no write changes any register, no read produces a strobe or clears a flag, and `rdata_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_i | input | 1 | Chip select |
| rd_i | input | 1 | Read strobe, one cycle per access |
| wr_i | input | 1 | Write strobe, one cycle per access |
| addr_i | input | 3 | Register offset |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational from offset |
| tx_valid_o | output | 1 | Transmit byte push |
| tx_data_o | output | 8 | Transmit byte |
| rx_data_i | input | 8 | Receive byte at head of core FIFO |
| rx_pop_o | output | 1 | Receive byte consumed |
| rx_flush_o | output | 1 | Receive FIFO flush pulse |
| tx_flush_o | output | 1 | Transmit FIFO flush pulse |
| fifo_en_o | output | 1 | FIFO enable |
| dma_mode_o | output | 1 | DMA signalling mode |
| lcr_o | output | 8 | Line control value |
| divisor_o | output | 16 | Baud divisor |
| ier_o | output | 8 | Interrupt enable bits |
| enh_mode_o | output | 1 | Enhanced bank unlocked |
| ext_bank_en_o | output | 1 | Extended register bank enable |
| idx_bank_en_o | output | 1 | Indexed register bank enable |
| dtr_o | output | 1 | DTR |
| rts_o | output | 1 | RTS |
| out2_o | output | 1 | Interrupt output enable |
| loop_o | output | 1 | Internal loopback |
| irq_pend_i | input | 1 | Core has an interrupt pending |
| irq_code_i | input | 3 | Core interrupt priority code |
| rx_ready_i | input | 1 | Receive data ready |
| overrun_i | input | 1 | Overrun event |
| parity_err_i | input | 1 | Parity error event |
| framing_err_i | input | 1 | Framing error event |
| break_i | input | 1 | Break event |
| thr_empty_i | input | 1 | Holding register empty |
| tx_empty_i | input | 1 | Transmitter empty |
| fifo_err_i | input | 1 | Error somewhere in receive FIFO |
| cts_i | input | 1 | CTS line |
| dsr_i | input | 1 | DSR line |
| ri_i | input | 1 | RI line |
| dcd_i | input | 1 | DCD line |

## Verification
A wrong decode sends a write to the wrong register. The damage shows on the configuration outputs one cycle after the write edge, and in the read-back of the next access to either register. A wrong line control update after the unlock code shows as changed format bits on `lcr_o` on the very next cycle. It also moves the window, so offsets 0 and 1 return divisor bytes where data was expected. A lost or stuck status flag only shows when the host reads offset 5 or 6. The bench therefore reads each flag twice, which exposes both a missed set and a missed clear within two accesses.

// File: rtl/uart_regbank_pkg.sv
package uart_regbank_pkg;
  localparam int DW = 8;
  localparam int AW = 3;

  localparam logic [AW-1:0] OFS_DATA = 3'd0;
  localparam logic [AW-1:0] OFS_IEN  = 3'd1;
  localparam logic [AW-1:0] OFS_FIFO = 3'd2;
  localparam logic [AW-1:0] OFS_LINE = 3'd3;
  localparam logic [AW-1:0] OFS_MODM = 3'd4;
  localparam logic [AW-1:0] OFS_LSTA = 3'd5;
  localparam logic [AW-1:0] OFS_MSTA = 3'd6;
  localparam logic [AW-1:0] OFS_SCR  = 3'd7;

  typedef struct packed {
    logic thr_wr;
    logic dll_wr;
    logic dlm_wr;
    logic ier_wr;
    logic fcr_wr;
    logic acr_wr;
    logic lcr_wr;
    logic mcr_wr;
    logic scr_wr;
  } wr_sel_t;

  typedef struct packed {
    logic rhr_rd;
    logic lsr_rd;
    logic msr_rd;
  } rd_sel_t;
endpackage

// File: rtl/uart_rb_decode.sv
module uart_rb_decode
  import uart_regbank_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_i,
  input  logic          rd_i,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic          dlab_i,
  input  logic          enh_i,
  output wr_sel_t       wsel_o,
  output rd_sel_t       rsel_o
);
  logic wr_go, rd_go;
  assign wr_go = cs_i & wr_i;
  assign rd_go = cs_i & rd_i;

  always_comb begin
    wsel_o = '0;
    rsel_o = '0;
    if (wr_go) begin
      unique case (addr_i)
        OFS_DATA: if (dlab_i) wsel_o.dll_wr = 1'b1; else wsel_o.thr_wr = 1'b1;
        OFS_IEN:  if (dlab_i) wsel_o.dlm_wr = 1'b1; else wsel_o.ier_wr = 1'b1;
        OFS_FIFO: if (enh_i)  wsel_o.acr_wr = 1'b1; else wsel_o.fcr_wr = 1'b1;
        OFS_LINE: wsel_o.lcr_wr = 1'b1;
        OFS_MODM: wsel_o.mcr_wr = 1'b1;
        OFS_SCR:  wsel_o.scr_wr = 1'b1;
        default: ;
      endcase
    end
    if (rd_go) begin
      unique case (addr_i)
        OFS_DATA: rsel_o.rhr_rd = ~dlab_i;
        OFS_LSTA: rsel_o.lsr_rd = 1'b1;
        OFS_MSTA: rsel_o.msr_rd = 1'b1;
        default: ;
      endcase
    end
  end

  // R1: one access reaches at most one register
  a_r1_one_target: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wsel_o));
  // R11: no select, no target
  a_r11_no_cs_no_sel: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_i |-> (wsel_o == '0) && (rsel_o == '0));
endmodule

// File: rtl/uart_rb_lsr.sv
module uart_rb_lsr #(
  parameter int N_STICKY = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr_i,
  input  logic [N_STICKY-1:0] evt_i,
  input  logic                rx_ready_i,
  input  logic                thr_empty_i,
  input  logic                tx_empty_i,
  input  logic                fifo_err_i,
  output logic [7:0]          lsr_o
);
  logic [N_STICKY-1:0] flag_q;

  for (genvar i = 0; i < N_STICKY; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               flag_q[i] <= 1'b0;
      else if (evt_i[i])        flag_q[i] <= 1'b1;
      else if (clr_i)           flag_q[i] <= 1'b0;
    end
  end

  assign lsr_o = {fifo_err_i, tx_empty_i, thr_empty_i, flag_q, rx_ready_i};

  // R6: read with no new event empties the latched bits
  a_r6_clear_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && evt_i == '0) |=> (lsr_o[4:1] == '0));
  // R6: an event is always visible on the next cycle, read or not
  a_r6_event_kept: assert property (@(posedge clk) disable iff (!rst_n)
    evt_i[1] |=> lsr_o[2]);
endmodule

// File: rtl/uart_rb_msr.sv
module uart_rb_msr #(
  parameter int N_LINES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr_i,
  input  logic [N_LINES-1:0] ext_i,
  input  logic               loop_i,
  input  logic [N_LINES-1:0] loop_src_i,
  output logic [7:0]         msr_o
);
  logic [N_LINES-1:0] line_eff, line_prev_q, delta_q, edge_hit;

  assign line_eff = loop_i ? loop_src_i : ext_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_prev_q <= '0;
    else        line_prev_q <= line_eff;
  end

  for (genvar i = 0; i < N_LINES; i++) begin : g_delta
    if (i == 2) begin : g_trail
      assign edge_hit[i] = line_prev_q[i] & ~line_eff[i];
    end else begin : g_change
      assign edge_hit[i] = line_prev_q[i] ^ line_eff[i];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           delta_q[i] <= 1'b0;
      else if (edge_hit[i]) delta_q[i] <= 1'b1;
      else if (clr_i)       delta_q[i] <= 1'b0;
    end
  end

  assign msr_o = {line_eff, delta_q};

  // R7: a falling ring line is reported
  a_r7_ri_trailing: assert property (@(posedge clk) disable iff (!rst_n)
    (line_prev_q[2] && !line_eff[2]) |=> msr_o[2]);
  // R7: a rising ring line alone does not set the trailing flag
  a_r7_ri_rise_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!msr_o[2] && clr_i && !line_prev_q[2]) |=> !msr_o[2]);
endmodule

// File: rtl/uart_regbank.sv
module uart_regbank
  import uart_regbank_pkg::*;
#(
  parameter logic [7:0] UNLOCK_CODE = 8'hBF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cs_i,
  input  logic        rd_i,
  input  logic        wr_i,
  input  logic [2:0]  addr_i,
  input  logic [7:0]  wdata_i,
  output logic [7:0]  rdata_o,
  output logic        tx_valid_o,
  output logic [7:0]  tx_data_o,
  input  logic [7:0]  rx_data_i,
  output logic        rx_pop_o,
  output logic        rx_flush_o,
  output logic        tx_flush_o,
  output logic        fifo_en_o,
  output logic        dma_mode_o,
  output logic [7:0]  lcr_o,
  output logic [15:0] divisor_o,
  output logic [7:0]  ier_o,
  output logic        enh_mode_o,
  output logic        ext_bank_en_o,
  output logic        idx_bank_en_o,
  output logic        dtr_o,
  output logic        rts_o,
  output logic        out2_o,
  output logic        loop_o,
  input  logic        irq_pend_i,
  input  logic [2:0]  irq_code_i,
  input  logic        rx_ready_i,
  input  logic        overrun_i,
  input  logic        parity_err_i,
  input  logic        framing_err_i,
  input  logic        break_i,
  input  logic        thr_empty_i,
  input  logic        tx_empty_i,
  input  logic        fifo_err_i,
  input  logic        cts_i,
  input  logic        dsr_i,
  input  logic        ri_i,
  input  logic        dcd_i
);
  localparam int MCR_W = 5;

  logic [DW-1:0]    lcr_q, dll_q, dlm_q, ier_q, scr_q, acr_q, tx_data_q;
  logic [MCR_W-1:0] mcr_q;
  logic             enh_q, fifo_en_q, dma_q;
  logic             tx_valid_q, rx_pop_q, rx_flush_q, tx_flush_q;
  logic [7:0]       lsr_w, msr_w, isr_w;
  wr_sel_t          wsel;
  rd_sel_t          rsel;

  uart_rb_decode u_dec (
    .clk    (clk),
    .rst_n  (rst_n),
    .cs_i   (cs_i),
    .rd_i   (rd_i),
    .wr_i   (wr_i),
    .addr_i (addr_i),
    .dlab_i (lcr_q[7]),
    .enh_i  (enh_q),
    .wsel_o (wsel),
    .rsel_o (rsel)
  );

  uart_rb_lsr #(.N_STICKY(4)) u_lsr (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr_i       (rsel.lsr_rd),
    .evt_i       ({break_i, framing_err_i, parity_err_i, overrun_i}),
    .rx_ready_i  (rx_ready_i),
    .thr_empty_i (thr_empty_i),
    .tx_empty_i  (tx_empty_i),
    .fifo_err_i  (fifo_err_i),
    .lsr_o       (lsr_w)
  );

  uart_rb_msr #(.N_LINES(4)) u_msr (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (rsel.msr_rd),
    .ext_i      ({dcd_i, ri_i, dsr_i, cts_i}),
    .loop_i     (mcr_q[4]),
    .loop_src_i ({mcr_q[3], mcr_q[2], mcr_q[0], mcr_q[1]}),
    .msr_o      (msr_w)
  );

  // line control and unlock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lcr_q <= '0;
      enh_q <= 1'b0;
    end else if (wsel.lcr_wr) begin
      if (wdata_i == UNLOCK_CODE) begin
        enh_q    <= 1'b1;
        lcr_q[7] <= 1'b1;
      end else begin
        enh_q <= 1'b0;
        lcr_q <= wdata_i;
      end
    end
  end

  // plain stored registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dll_q     <= '0;
      dlm_q     <= '0;
      ier_q     <= '0;
      scr_q     <= '0;
      acr_q     <= '0;
      mcr_q     <= '0;
      fifo_en_q <= 1'b0;
      dma_q     <= 1'b0;
    end else begin
      if (wsel.dll_wr) dll_q <= wdata_i;
      if (wsel.dlm_wr) dlm_q <= wdata_i;
      if (wsel.ier_wr) ier_q <= wdata_i;
      if (wsel.scr_wr) scr_q <= wdata_i;
      if (wsel.acr_wr) acr_q <= wdata_i;
      if (wsel.mcr_wr) mcr_q <= wdata_i[MCR_W-1:0];
      if (wsel.fcr_wr) begin
        fifo_en_q <= wdata_i[0];
        dma_q     <= wdata_i[3];
      end
    end
  end

  // one-cycle strobes toward the core
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_valid_q <= 1'b0;
      tx_data_q  <= '0;
      rx_pop_q   <= 1'b0;
      rx_flush_q <= 1'b0;
      tx_flush_q <= 1'b0;
    end else begin
      tx_valid_q <= wsel.thr_wr;
      if (wsel.thr_wr) tx_data_q <= wdata_i;
      rx_pop_q   <= rsel.rhr_rd;
      rx_flush_q <= wsel.fcr_wr & wdata_i[1];
      tx_flush_q <= wsel.fcr_wr & wdata_i[2];
    end
  end

  assign isr_w = {fifo_en_q, fifo_en_q, 2'b00, irq_code_i, ~irq_pend_i};

  always_comb begin
    rdata_o = '0;
    if (cs_i) begin
      unique case (addr_i)
        OFS_DATA: rdata_o = lcr_q[7] ? dll_q : rx_data_i;
        OFS_IEN:  rdata_o = lcr_q[7] ? dlm_q : ier_q;
        OFS_FIFO: rdata_o = enh_q ? acr_q : isr_w;
        OFS_LINE: rdata_o = lcr_q;
        OFS_MODM: rdata_o = {{(DW-MCR_W){1'b0}}, mcr_q};
        OFS_LSTA: rdata_o = lsr_w;
        OFS_MSTA: rdata_o = msr_w;
        OFS_SCR:  rdata_o = scr_q;
        default:  rdata_o = '0;
      endcase
    end
  end

  assign tx_valid_o    = tx_valid_q;
  assign tx_data_o     = tx_data_q;
  assign rx_pop_o      = rx_pop_q;
  assign rx_flush_o    = rx_flush_q;
  assign tx_flush_o    = tx_flush_q;
  assign fifo_en_o     = fifo_en_q;
  assign dma_mode_o    = dma_q;
  assign lcr_o         = lcr_q;
  assign divisor_o     = {dlm_q, dll_q};
  assign ier_o         = ier_q;
  assign enh_mode_o    = enh_q;
  assign ext_bank_en_o = acr_q[7];
  assign idx_bank_en_o = acr_q[6];
  assign dtr_o         = mcr_q[0];
  assign rts_o         = mcr_q[1];
  assign out2_o        = mcr_q[3];
  assign loop_o        = mcr_q[4];

  // R3: unlock keeps the data format bits
  a_r3_unlock_keeps_fmt: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_i && wr_i && addr_i == OFS_LINE && wdata_i == UNLOCK_CODE)
      |=> enh_mode_o && lcr_o[7] && (lcr_o[6:0] == $past(lcr_o[6:0])));
  // R4: additional control frozen outside enhanced mode
  a_r4_acr_locked: assert property (@(posedge clk) disable iff (!rst_n)
    !enh_mode_o |=> $stable(acr_q));
  // R2: a data write becomes one push carrying the byte
  a_r2_tx_push: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_i && wr_i && addr_i == OFS_DATA && !lcr_o[7])
      |=> tx_valid_o && (tx_data_o == $past(wdata_i)));
  // R5: flush pulse only after a FIFO control write outside enhanced mode
  a_r5_flush_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (!(cs_i && wr_i && addr_i == OFS_FIFO && !enh_mode_o)) |=> !rx_flush_o && !tx_flush_o);
  // R11: no strobe without chip select
  a_r11_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_i |=> !tx_valid_o && !rx_pop_o);
endmodule

// File: tb/uart_regbank_tb_top.sv
module uart_regbank_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_i = 0, rd_i = 0, wr_i = 0;
  logic [2:0]  addr_i = '0;
  logic [7:0]  wdata_i = '0, rx_data_i = '0;
  logic        irq_pend_i = 0;
  logic [2:0]  irq_code_i = '0;
  logic        rx_ready_i = 0, overrun_i = 0, parity_err_i = 0, framing_err_i = 0;
  logic        break_i = 0, thr_empty_i = 0, tx_empty_i = 0, fifo_err_i = 0;
  logic        cts_i = 0, dsr_i = 0, ri_i = 0, dcd_i = 0;
  logic [7:0]  rdata_o, tx_data_o, lcr_o, ier_o;
  logic [15:0] divisor_o;
  logic        tx_valid_o, rx_pop_o, rx_flush_o, tx_flush_o, fifo_en_o, dma_mode_o;
  logic        enh_mode_o, ext_bank_en_o, idx_bank_en_o, dtr_o, rts_o, out2_o, loop_o;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  uart_regbank dut_i (.*);

  // vector: {is_write, offset, data, expected read}
  localparam int NV = 20;
  localparam logic [19:0] VEC [NV] = '{
    {1'b1, 3'd3, 8'h83, 8'h00},  // R1 open divisor
    {1'b1, 3'd0, 8'h34, 8'h00},
    {1'b1, 3'd1, 8'h12, 8'h00},
    {1'b0, 3'd0, 8'h00, 8'h34},  // R1
    {1'b0, 3'd1, 8'h00, 8'h12},  // R1
    {1'b1, 3'd3, 8'h03, 8'h00},
    {1'b0, 3'd3, 8'h00, 8'h03},  // R3
    {1'b1, 3'd1, 8'h0F, 8'h00},
    {1'b0, 3'd1, 8'h00, 8'h0F},  // R2 ier
    {1'b1, 3'd7, 8'hA5, 8'h00},
    {1'b0, 3'd7, 8'h00, 8'hA5},  // R9
    {1'b1, 3'd4, 8'h0B, 8'h00},
    {1'b0, 3'd4, 8'h00, 8'h0B},  // R8
    {1'b1, 3'd3, 8'hBF, 8'h00},
    {1'b0, 3'd3, 8'h00, 8'h83},  // R3 unlock keeps 6:0
    {1'b1, 3'd2, 8'hC0, 8'h00},
    {1'b0, 3'd2, 8'h00, 8'hC0},  // R4
    {1'b1, 3'd3, 8'h1B, 8'h00},
    {1'b0, 3'd3, 8'h00, 8'h1B},  // R3 exit
    {1'b0, 3'd2, 8'h00, 8'h01}   // R5 status, nothing pending
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_wr(input logic [2:0] a, input logic [7:0] d, input logic sel = 1'b1);
    @(negedge clk);
    cs_i = sel; wr_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk);
    cs_i = 1'b0; wr_i = 1'b0;
  endtask

  task automatic do_rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    cs_i = 1'b1; rd_i = 1'b1; addr_i = a;
    #1 d = rdata_o;
    @(negedge clk);
    cs_i = 1'b0; rd_i = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(1);
    // R10 reset state
    do_rd(3'd3, r);       chk("R10 lcr", r, 8'h00);
    chk("R10 divisor", divisor_o, 16'h0000);
    chk("R10 enh", enh_mode_o, 1'b0);
    chk("R10 mcr pins", {dtr_o, rts_o, out2_o, loop_o}, 4'h0);
    chk("R10 strobes", {tx_valid_o, rx_flush_o, tx_flush_o}, 3'b000);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][19]) do_wr(VEC[i][18:16], VEC[i][15:8]);
      else begin
        do_rd(VEC[i][18:16], r);
        chk($sformatf("R1-table step %0d (R3 R4 R8 R9 R2 R5)", i), r, VEC[i][7:0]);
      end
    end
    chk("R1 divisor_o", divisor_o, 16'h1234);
    chk("R4 bank enables", {ext_bank_en_o, idx_bank_en_o}, 2'b11);
    chk("R3 enh exit", enh_mode_o, 1'b0);
    chk("R8 pins", {dtr_o, rts_o, out2_o, loop_o}, 4'b1110);

    // R2 push and pop
    do_wr(3'd0, 8'h5A);
    chk("R2 tx push", {tx_valid_o, tx_data_o}, {1'b1, 8'h5A});
    idle(1);
    chk("R2 tx single", tx_valid_o, 1'b0);
    rx_data_i = 8'h77;
    do_rd(3'd0, r);
    chk("R2 rx data", r, 8'h77);
    chk("R2 rx pop", rx_pop_o, 1'b1);
    idle(1);
    chk("R2 rx pop single", rx_pop_o, 1'b0);

    // R5 FIFO control, R4 ACR untouched
    do_wr(3'd2, 8'h0F);
    chk("R5 flush pulses", {rx_flush_o, tx_flush_o}, 2'b11);
    chk("R5 fifo/dma", {fifo_en_o, dma_mode_o}, 2'b11);
    chk("R4 acr untouched", {ext_bank_en_o, idx_bank_en_o}, 2'b11);
    idle(1);
    chk("R5 flush single", {rx_flush_o, tx_flush_o}, 2'b00);
    irq_pend_i = 1'b1; irq_code_i = 3'b010;
    do_rd(3'd2, r);
    chk("R5 status word", r, 8'hC4);

    // R6 line status
    rx_ready_i = 1; thr_empty_i = 1;
    @(negedge clk); parity_err_i = 1;
    @(negedge clk); parity_err_i = 0;
    do_rd(3'd5, r);       chk("R6 latched parity", r, 8'h25);
    do_rd(3'd5, r);       chk("R6 cleared", r, 8'h21);
    @(negedge clk);
    cs_i = 1; rd_i = 1; addr_i = 3'd5; framing_err_i = 1;
    @(negedge clk);
    cs_i = 0; rd_i = 0; framing_err_i = 0;
    do_rd(3'd5, r);       chk("R6 event during read kept", r, 8'h29);

    // R7 modem status
    @(negedge clk); cts_i = 1;
    idle(2);
    do_rd(3'd6, r);       chk("R7 delta cts", r, 8'h11);
    do_rd(3'd6, r);       chk("R7 delta cleared", r, 8'h10);
    ri_i = 1; idle(2);
    do_rd(3'd6, r);       chk("R7 ri rise no flag", r, 8'h50);
    ri_i = 0; idle(2);
    do_rd(3'd6, r);       chk("R7 ri trailing", r, 8'h14);

    // R8 loopback
    do_wr(3'd4, 8'h13);
    idle(1);
    chk("R8 loop pin", loop_o, 1'b1);
    do_rd(3'd6, r);       chk("R8 loopback lines", r, 8'h32);

    // R11 no chip select
    do_wr(3'd7, 8'hFF, 1'b0);
    chk("R11 no push", tx_valid_o, 1'b0);
    do_rd(3'd7, r);       chk("R11 scratch kept", r, 8'hA5);
    @(negedge clk); addr_i = 3'd7; #1;
    chk("R11 rdata idle", rdata_o, 8'h00);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule